// File: doc/BRIEF.md
# Streaming Bus-Master DMA Engine

This block turns one decoded memory-mapped command into a run of 32-bit Wishbone master cycles. A command gives a start address, a length in bytes (1 to 8192) and a direction. A flag selects between two addressing modes. In incrementing mode the address steps through a memory range. In constant mode every word hits the same address, which suits FIFO-style ports. Write words are pulled from an input word stream. Read words are pushed onto an output word stream toward the response side.

The engine keeps one bus word in flight at a time. It holds the bus cycle open for the whole command and strobes once per word. It finishes with a one-cycle completion pulse and an error flag. The error flag is raised when a slave answers with a bus error, or when no acknowledge arrives within a programmable number of strobe cycles. Address decoding and slave routing sit outside the block.

Top module: `wb_stream_dma`

## Requirements
- R1: After reset, `wb_cyc_o`, `wb_stb_o`, `rd_valid` and `done` are low, and `cmd_ready` is high.
- R2: A command is taken only while idle. `cmd_ready` is low from the cycle after acceptance until the completion pulse.
- R3: A command of L bytes (1..8192) performs exactly ceil(L/4) acknowledged word cycles. A length that is not a multiple of 4 is rounded up, so 10 bytes give 3 words and 8192 bytes give 2048 words.
- R4: In incrementing mode (`cmd_fixed`=0) the first word uses `cmd_addr` and each later word adds 4. In constant mode (`cmd_fixed`=1) every word uses `cmd_addr`. The address is stable while a strobe waits.
- R5: `wb_cyc_o` stays high for the whole command and is high whenever `wb_stb_o` is. A strobed word completes in the cycle where `wb_ack_i` is seen. `wb_sel_o` is 4'b1111 on every strobe, and `wb_we_o` follows `cmd_write`.
- R6: On writes, one word is taken from the write stream (`wd_valid`&`wd_ready`) per bus word, in stream order. No strobe is raised while the stream is empty.
- R7: On reads, acknowledged data appear on `rd_data` with `rd_valid` in bus order, and are held until `rd_ready`. No further strobe is issued while an unconsumed word is pending.
- R8: If `wb_stb_o` stays high for `tmo_limit` cycles with no acknowledge, the command aborts. The abort drops `wb_cyc_o` and gives `done` with `done_err`=1. A `tmo_limit` of 0 disables the timeout.
- R9: `wb_err_i` during a strobe aborts the command at once with `done` and `done_err`=1. No further words are issued.
- R10: `done` is a one-cycle pulse, raised the cycle after the final acknowledge. On success `done_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_limit | input | 16 | Strobe cycles allowed without acknowledge; 0 disables |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_fixed | input | 1 | 1 = constant address, 0 = incrementing |
| cmd_addr | input | 32 | Start byte address |
| cmd_len | input | 14 | Transfer length in bytes |
| wd_valid | input | 1 | Write word available |
| wd_ready | output | 1 | Write word taken |
| wd_data | input | 32 | Write word |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Read word consumed |
| rd_data | output | 32 | Read word |
| done | output | 1 | Command finished (pulse) |
| done_err | output | 1 | Command ended by bus error or timeout |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_sel_o | output | 4 | Byte selects |
| wb_adr_o | output | 32 | Bus address |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack_i | input | 1 | Slave acknowledge |
| wb_err_i | input | 1 | Slave error |

## Verification
The bench goes after the following corner cases, with the failure each one catches:
- A 10-byte read must produce three words. A design that truncates the length loses the last word.
- A gappy write stream must not cause spurious strobes. An engine that ignores `wd_valid` would push stale data to the slave.
- A stalled read consumer must stop further strobes. An engine that keeps strobing would read a FIFO port past the pending word and drop data.
- A silent slave must be cut off after exactly the programmed number of strobe cycles.
- An error on the second word must stop the command there, with the error flag set.
- Constant-mode runs must keep one address. An engine that always increments would walk off a port address.
- The full 8192-byte length must give 2048 words. A narrow counter would wrap and lose words.

// File: rtl/wsdma_pkg.sv
package wsdma_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dma_st_e;
endpackage

// File: rtl/wsdma_len2words.sv
// Converts a byte count to a whole-word count, rounding up; zero maps to one word.
module wsdma_len2words #(
    parameter int LEN_W  = 14,
    parameter int WCNT_W = 12,
    parameter int OFS_W  = 2
) (
    input  logic [LEN_W-1:0]  len_i,
    output logic [WCNT_W-1:0] words_o
);
    localparam logic [LEN_W:0] ROUND = (LEN_W+1)'((1 << OFS_W) - 1);

    logic [LEN_W:0] sum;

    always_comb begin
        sum = {1'b0, len_i} + ROUND;
        if (len_i == '0) begin
            words_o = WCNT_W'(1);
        end else begin
            words_o = WCNT_W'(sum >> OFS_W);
        end
    end
endmodule

// File: rtl/wsdma_addr_step.sv
// Next bus address: fixed for port access, otherwise one word further.
module wsdma_addr_step #(
    parameter int ADDR_W = 32,
    parameter int BPW    = 4
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic              fixed_i,
    output logic [ADDR_W-1:0] nxt_o
);
    always_comb begin
        if (fixed_i) begin
            nxt_o = cur_i;
        end else begin
            nxt_o = cur_i + ADDR_W'(BPW);
        end
    end
endmodule

// File: rtl/wsdma_ack_timer.sv
// Counts strobe cycles without a response and flags expiry on the last allowed one.
module wsdma_ack_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             resp_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expire_o
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = active_i && !resp_i && (limit_i != '0) &&
                   (cnt_q == limit_i - TMO_W'(1));
        if (active_i && !resp_i && !expire_o) begin
            cnt_d = cnt_q + TMO_W'(1);
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/wb_stream_dma.sv
// Executes one read or write command as a series of single-word bus cycles.
module wb_stream_dma #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_BYTES = 8192,
    parameter int TMO_W     = 16,
    parameter int LEN_W     = $clog2(MAX_BYTES) + 1,
    parameter int SEL_W     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic              cmd_fixed,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [DATA_W-1:0] wd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              done_err,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [SEL_W-1:0]  wb_sel_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i,
    input  logic              wb_err_i
);
    import wsdma_pkg::*;

    localparam int BPW    = DATA_W / 8;
    localparam int OFS_W  = $clog2(BPW);
    localparam int WCNT_W = $clog2(MAX_BYTES / BPW) + 1;

    typedef struct packed {
        dma_st_e            st;
        logic               we;
        logic               fixed;
        logic [ADDR_W-1:0]  adr;
        logic [WCNT_W-1:0]  left;
        logic               stb;
        logic [DATA_W-1:0]  wdat;
        logic               rdv;
        logic [DATA_W-1:0]  rdat;
        logic               done;
        logic               err;
    } regs_t;

    regs_t d, q;

    logic [WCNT_W-1:0] cmd_words;
    logic [ADDR_W-1:0] adr_next;
    logic              tmo_expire;

    wsdma_len2words #(
        .LEN_W (LEN_W),
        .WCNT_W(WCNT_W),
        .OFS_W (OFS_W)
    ) u_len (
        .len_i  (cmd_len),
        .words_o(cmd_words)
    );

    wsdma_addr_step #(
        .ADDR_W(ADDR_W),
        .BPW   (BPW)
    ) u_step (
        .cur_i  (q.adr),
        .fixed_i(q.fixed),
        .nxt_o  (adr_next)
    );

    wsdma_ack_timer #(
        .TMO_W(TMO_W)
    ) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(q.stb),
        .resp_i  (wb_ack_i || wb_err_i),
        .limit_i (tmo_limit),
        .expire_o(tmo_expire)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;

        if (q.rdv && rd_ready) begin
            d.rdv = 1'b0;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.st    = ST_RUN;
                    d.we    = cmd_write;
                    d.fixed = cmd_fixed;
                    d.adr   = cmd_addr;
                    d.left  = cmd_words;
                end
            end
            ST_RUN: begin
                if (!q.stb) begin
                    if (q.we) begin
                        if (wd_valid) begin
                            d.stb  = 1'b1;
                            d.wdat = wd_data;
                        end
                    end else if (!q.rdv) begin
                        d.stb = 1'b1;
                    end
                end else if (wb_err_i || tmo_expire) begin
                    d.stb  = 1'b0;
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                end else if (wb_ack_i) begin
                    d.stb  = 1'b0;
                    d.left = q.left - WCNT_W'(1);
                    d.adr  = adr_next;
                    if (!q.we) begin
                        d.rdat = wb_dat_i;
                        d.rdv  = 1'b1;
                    end
                    if (q.left == WCNT_W'(1)) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.st == ST_IDLE);
    assign wd_ready  = (q.st == ST_RUN) && q.we && !q.stb;
    assign rd_valid  = q.rdv;
    assign rd_data   = q.rdat;
    assign done      = q.done;
    assign done_err  = q.err;
    assign wb_cyc_o  = (q.st == ST_RUN);
    assign wb_stb_o  = q.stb;
    assign wb_we_o   = q.we;
    assign wb_sel_o  = '1;
    assign wb_adr_o  = q.adr;
    assign wb_dat_o  = q.wdat;
endmodule

// File: rtl/wsdma_chk.sv
// Protocol properties of the DMA master, attached by bind.
module wsdma_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SEL_W  = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              wd_valid,
    input logic              wd_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              done,
    input logic              done_err,
    input logic              wb_cyc_o,
    input logic              wb_stb_o,
    input logic              wb_we_o,
    input logic [SEL_W-1:0]  wb_sel_o,
    input logic [ADDR_W-1:0] wb_adr_o,
    input logic              wb_ack_i,
    input logic              wb_err_i
);
    p_stb_in_cyc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o |-> wb_cyc_o);

    p_sel_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o |-> (wb_sel_o == '1));

    p_stb_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && !wb_ack_i && !wb_err_i) |=> (wb_stb_o || done));

    p_adr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb_o && !wb_ack_i && !wb_err_i) |=> (!wb_stb_o || $stable(wb_adr_o)));

    p_busy_no_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o |-> !cmd_ready);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> done);

    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    p_rd_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wb_stb_o) && !wb_we_o) |-> !rd_valid);

    p_wr_fed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wb_stb_o) && wb_we_o) |-> $past(wd_valid && wd_ready));
endmodule

bind wb_stream_dma wsdma_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ready(cmd_ready),
    .wd_valid (wd_valid),
    .wd_ready (wd_ready),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .done     (done),
    .done_err (done_err),
    .wb_cyc_o (wb_cyc_o),
    .wb_stb_o (wb_stb_o),
    .wb_we_o  (wb_we_o),
    .wb_sel_o (wb_sel_o),
    .wb_adr_o (wb_adr_o),
    .wb_ack_i (wb_ack_i),
    .wb_err_i (wb_err_i)
);

// File: tb/wb_stream_dma_tb.sv
module wb_stream_dma_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PORT_ADR = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmo_limit = 16'd256;
    logic        cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0, cmd_fixed = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [13:0] cmd_len = '0;
    logic        wd_valid, wd_ready;
    logic [31:0] wd_data;
    logic        rd_valid, rd_ready = 1'b1;
    logic [31:0] rd_data;
    logic        done, done_err;
    logic        wb_cyc_o, wb_stb_o, wb_we_o;
    logic [3:0]  wb_sel_o;
    logic [31:0] wb_adr_o, wb_dat_o;
    logic [31:0] s_dat = '0;
    logic        s_ack = 1'b0, s_err = 1'b0;

    int checks = 0, fails = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_stream_dma u_dut (
        .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_fixed(cmd_fixed), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .done_err(done_err),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
        .wb_sel_o(wb_sel_o), .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o),
        .wb_dat_i(s_dat), .wb_ack_i(s_ack), .wb_err_i(s_err)
    );

    // Write-data source: counting words, optionally gappy
    int   wd_idx = 0, tick = 0;
    logic wd_en = 1'b0, wd_gappy = 1'b0;
    assign wd_data  = 32'hA000_0000 + 32'(wd_idx);
    assign wd_valid = wd_en && (!wd_gappy || (tick % 4 == 0));
    always @(posedge clk) begin
        tick <= tick + 1;
        if (wd_valid && wd_ready) wd_idx <= wd_idx + 1;
    end

    // Read-data sink
    logic [31:0] rd_log [64];
    int rd_n = 0;
    always @(posedge clk) begin
        if (rd_valid && rd_ready) begin
            if (rd_n < 64) rd_log[rd_n] <= rd_data;
            rd_n <= rd_n + 1;
        end
    end

    // Slave model: registered ack, optional delay, mute and error injection
    logic [31:0] mem [64];
    logic [31:0] alog [64];
    logic [31:0] f_last = '0;
    int alog_n = 0, s_acks = 0, resp_n = 0, stb_cyc = 0, s_badsel = 0;
    int f_wr = 0, f_rd = 0, dcnt = 0, s_delay = 0, s_err_at = -1;
    logic s_mute = 1'b0;

    always @(posedge clk) begin
        s_ack <= 1'b0;
        s_err <= 1'b0;
        if (wb_stb_o) stb_cyc = stb_cyc + 1;
        if (wb_cyc_o && wb_stb_o && !s_ack && !s_err && !s_mute) begin
            if (dcnt < s_delay) begin
                dcnt = dcnt + 1;
            end else begin
                dcnt   = 0;
                resp_n = resp_n + 1;
                if (resp_n == s_err_at) begin
                    s_err <= 1'b1;
                end else begin
                    s_ack <= 1'b1;
                    s_acks = s_acks + 1;
                    if (wb_sel_o != 4'hF) s_badsel = s_badsel + 1;
                    if (alog_n < 64) alog[alog_n] = wb_adr_o;
                    alog_n = alog_n + 1;
                    if (wb_we_o) begin
                        if (wb_adr_o == PORT_ADR) begin
                            f_wr = f_wr + 1;
                            f_last = wb_dat_o;
                        end else begin
                            mem[wb_adr_o[7:2]] = wb_dat_o;
                        end
                    end else begin
                        if (wb_adr_o == PORT_ADR) begin
                            s_dat <= 32'hF000_0000 + 32'(f_rd);
                            f_rd = f_rd + 1;
                        end else begin
                            s_dat <= mem[wb_adr_o[7:2]];
                        end
                    end
                end
            end
        end else begin
            dcnt = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic we, input logic [31:0] a, input int len, input logic fx);
        @(negedge clk);
        cmd_write = we; cmd_addr = a; cmd_len = 14'(len); cmd_fixed = fx; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!cmd_ready, "R2", "cmd_ready while busy", 32'(cmd_ready), 0);
    endtask

    task automatic wait_done(output logic err);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 20000);
        err = done_err;
        check(done == 1'b1, "R10", "done seen", 32'(done), 1);
        @(negedge clk);
        check(!done, "R10", "done one cycle", 32'(done), 0);
    endtask

    task automatic t_reset();
        check(!wb_cyc_o && !wb_stb_o, "R1", "bus idle", {30'b0, wb_cyc_o, wb_stb_o}, 0);
        check(cmd_ready, "R1", "cmd_ready", 32'(cmd_ready), 1);
        check(!rd_valid && !done, "R1", "rd_valid/done", {30'b0, rd_valid, done}, 0);
    endtask

    task automatic t_write_incr();
        int w0 = wd_idx, a0 = alog_n, k0 = s_acks;
        logic e;
        wd_en = 1'b1;
        issue(1'b1, 32'h20, 12, 1'b0);
        wait_done(e);
        wd_en = 1'b0;
        check(!e, "R10", "no error on success", 32'(e), 0);
        check(s_acks - k0 == 3, "R3", "12B word count", 32'(s_acks - k0), 3);
        for (int i = 0; i < 3; i++) begin
            check(alog[a0+i] == 32'h20 + 32'(4*i), "R4", "incr address", alog[a0+i], 32'h20 + 32'(4*i));
            check(mem[8+i] == 32'hA000_0000 + 32'(w0+i), "R6", "write order", mem[8+i], 32'hA000_0000 + 32'(w0+i));
        end
        check(s_badsel == 0, "R5", "sel all ones", 32'(s_badsel), 0);
    endtask

    task automatic t_read_round(input int w0);
        int r0 = rd_n, k0 = s_acks;
        logic e;
        issue(1'b0, 32'h20, 10, 1'b0);
        wait_done(e);
        @(negedge clk);
        check(s_acks - k0 == 3, "R3", "10B rounds to 3 words", 32'(s_acks - k0), 3);
        check(rd_n - r0 == 3, "R7", "read words out", 32'(rd_n - r0), 3);
        for (int i = 0; i < 3; i++)
            check(rd_log[r0+i] == 32'hA000_0000 + 32'(w0+i), "R7", "read order",
                  rd_log[r0+i], 32'hA000_0000 + 32'(w0+i));
    endtask

    task automatic t_fixed_write_gappy();
        int w0 = wd_idx, a0 = alog_n, f0 = f_wr;
        logic e;
        wd_en = 1'b1; wd_gappy = 1'b1;
        issue(1'b1, PORT_ADR, 16, 1'b1);
        wait_done(e);
        wd_en = 1'b0; wd_gappy = 1'b0;
        check(f_wr - f0 == 4, "R6", "port writes with gaps", 32'(f_wr - f0), 4);
        check(f_last == 32'hA000_0000 + 32'(w0+3), "R6", "last port word", f_last, 32'hA000_0000 + 32'(w0+3));
        check(wd_idx - w0 == 4, "R6", "stream words consumed", 32'(wd_idx - w0), 4);
        for (int i = 0; i < 4; i++)
            check(alog[a0+i] == PORT_ADR, "R4", "constant address", alog[a0+i], PORT_ADR);
    endtask

    task automatic t_read_backpressure();
        int f0 = f_rd, r0 = rd_n;
        logic e;
        rd_ready = 1'b0;
        issue(1'b0, PORT_ADR, 12, 1'b1);
        repeat (20) @(negedge clk);
        check(f_rd - f0 == 1, "R7", "strobes held while full", 32'(f_rd - f0), 1);
        check(rd_valid && rd_data == 32'hF000_0000 + 32'(f0), "R7", "pending word held",
              rd_data, 32'hF000_0000 + 32'(f0));
        rd_ready = 1'b1;
        wait_done(e);
        @(negedge clk);
        check(rd_n - r0 == 3, "R7", "all words delivered", 32'(rd_n - r0), 3);
        for (int i = 0; i < 3; i++)
            check(rd_log[r0+i] == 32'hF000_0000 + 32'(f0+i), "R7", "port read order",
                  rd_log[r0+i], 32'hF000_0000 + 32'(f0+i));
    endtask

    task automatic t_timeout();
        int s0;
        logic e;
        tmo_limit = 16'd8; s_mute = 1'b1;
        s0 = stb_cyc;
        issue(1'b0, 32'h0, 4, 1'b0);
        wait_done(e);
        check(e, "R8", "timeout error", 32'(e), 1);
        check(stb_cyc - s0 == 8, "R8", "strobe cycles before abort", 32'(stb_cyc - s0), 8);
        check(!wb_cyc_o, "R8", "cyc dropped", 32'(wb_cyc_o), 0);
        s_mute = 1'b0; tmo_limit = 16'd256;
    endtask

    task automatic t_no_timeout();
        logic e;
        tmo_limit = 16'd0; s_delay = 300;
        issue(1'b0, 32'h20, 4, 1'b0);
        wait_done(e);
        check(!e, "R8", "limit 0 disables timeout", 32'(e), 0);
        s_delay = 0; tmo_limit = 16'd256;
    endtask

    task automatic t_bus_err();
        int k0 = s_acks;
        logic e;
        s_err_at = resp_n + 2;
        wd_en = 1'b1;
        issue(1'b1, 32'h40, 16, 1'b0);
        wait_done(e);
        wd_en = 1'b0;
        check(e, "R9", "bus error flagged", 32'(e), 1);
        check(s_acks - k0 == 1, "R9", "words before abort", 32'(s_acks - k0), 1);
        repeat (3) @(negedge clk);
        check(!wb_cyc_o && cmd_ready, "R9", "idle after abort", 32'(wb_cyc_o), 0);
        s_err_at = -1;
    endtask

    task automatic t_max_len();
        int k0 = s_acks, r0 = rd_n;
        logic e;
        issue(1'b0, PORT_ADR, 8192, 1'b1);
        wait_done(e);
        @(negedge clk);
        check(s_acks - k0 == 2048, "R3", "8192B gives 2048 words", 32'(s_acks - k0), 2048);
        check(rd_n - r0 == 2048, "R7", "2048 words delivered", 32'(rd_n - r0), 2048);
        check(!e, "R10", "no error on long run", 32'(e), 0);
    endtask

    initial begin
        int w_first;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        w_first = wd_idx;
        t_write_incr();
        t_read_round(w_first);
        t_fixed_write_gappy();
        t_read_backpressure();
        t_timeout();
        t_no_timeout();
        t_bus_err();
        t_max_len();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule